// File: doc/BRIEF.md
# Video Field Timing Decoder

This block recovers vertical timing from two incoming video timing signals: an active-low horizontal sync and an odd/even field level. It counts lines within a frame for either a 525-line or a 625-line standard, flags the start of each frame, reports which field is in progress, and produces a per-line blanking flag. The flag either follows an external blanking input or is generated from the line count, so that the standard's vertical blanking lines are blanked when no external blanking is supplied.

The vertical reference is the field input. A change on it counts only while horizontal sync is at its inactive (high) level. A change to the first-field level starts a new frame. A change to the second-field level only updates the field identity. All three timing inputs pass through two-flop synchronizers before any edge is detected. The decoder runs only when the timing-mode field selects this mode. The master/slave bit of that field does not change the decoding.

Top module: `vfield_decoder`

## Requirements
- R1: While `rstN` is low, and after it is released until the first effective input change, `lineNum` is 1, `fieldId` is 0, `frameStart` is 0 and `blankOut` is 1.
- R2: With the mode active, each falling edge of `hsyncN` (1 to 0) adds one to `lineNum`. The new value appears on the third rising clock edge after the input change.
- R3: When `lineNum` equals the frame length (525 when `std625`=0, 625 when `std625`=1), the next `hsyncN` falling edge sets it to 1 and does not pulse `frameStart`.
- R4: A change of `fieldIn` from 1 to 0 while `hsyncN` is high sets `lineNum` to 1 and `fieldId` to 0. It also raises `frameStart` for one clock cycle, on the third rising edge after the input change.
- R5: A change of `fieldIn` from 0 to 1 while `hsyncN` is high sets `fieldId` to 1. It leaves `lineNum` unchanged and raises no `frameStart`.
- R6: A change of `fieldIn` while `hsyncN` is low is ignored. `lineNum` and `fieldId` keep their values and `frameStart` stays 0.
- R7: With `blankEn`=0 and `std625`=0, `blankOut` is 1 for lines 1 to 21 and 263 to 283 and 0 otherwise. It is registered one cycle after `lineNum`.
- R8: With `blankEn`=0 and `std625`=1, `blankOut` is 1 for lines 1 to 22 and 311 to 335 and 0 otherwise, with the same one-cycle lag.
- R9: With `blankEn`=1, `blankOut` equals `extBlank` (1 = blank) delayed by three clock edges, whatever the line count.
- R10: The mode is active when `modeSel` is 3'b110 or 3'b111, and `modeSel[0]` has no effect. In any other mode, `lineNum` and `fieldId` hold, `frameStart` stays 0 and `blankOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncN | input | 1 | Horizontal sync, active low |
| fieldIn | input | 1 | Field level: 0 first field, 1 second field |
| extBlank | input | 1 | External blanking, 1 = blank |
| blankEn | input | 1 | 1 selects the external blanking input |
| std625 | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| modeSel | input | 3 | Timing-mode field; bit 0 is master/slave |
| lineNum | output | 10 | Current line within the frame, 1-based |
| fieldId | output | 1 | Field in progress: 0 first, 1 second |
| frameStart | output | 1 | One-cycle pulse at a detected frame start |
| blankOut | output | 1 | Line blanking flag |

## Verification
The bench aims at the following corner cases:
- **Frame-length wrap for both standards.** A counter with the wrong limit would run past 525 or stop early.
- **Field changes placed inside the sync pulse.** A decoder that skips the sync-level qualification would reset the line count in mid-frame.
- **A rising field change in mid-frame.** A design that treats every field edge as a frame start would send the count back to 1 at the second field.
- **Blanking window boundaries.** Off-by-one window limits show up as a wrong flag on the first or last blanked line.
- **Mode switches.** Switching to the master variant and to inactive modes catches decoding that depends on the master/slave bit or keeps counting while disabled.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam int LINES_525 = 525;
  localparam int LINES_625 = 625;
  localparam int LINE_W = $clog2(LINES_625 + 1);

  // vertical blanking windows, frame-relative line numbers
  localparam int B525_A_END   = 21;
  localparam int B525_B_START = 263;
  localparam int B525_B_END   = 283;
  localparam int B625_A_END   = 22;
  localparam int B625_B_START = 311;
  localparam int B625_B_END   = 335;

  typedef logic [LINE_W-1:0] line_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic lineAdv;
    logic fieldLoad;
    logic fieldVal;
    logic frameLoad;
  } strobe_t;

  function automatic line_t frameLength(input logic is625);
    return is625 ? line_t'(LINES_625) : line_t'(LINES_525);
  endfunction

  function automatic logic stdBlank(input logic is625, input line_t ln);
    logic res;
    if (is625)
      res = (ln <= line_t'(B625_A_END)) ||
            ((ln >= line_t'(B625_B_START)) && (ln <= line_t'(B625_B_END)));
    else
      res = (ln <= line_t'(B525_A_END)) ||
            ((ln >= line_t'(B525_B_START)) && (ln <= line_t'(B525_B_END)));
    return res;
  endfunction

endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              fieldIn,
  input  logic              extBlank,
  input  logic [MODE_W-1:0] modeSel,
  output strobe_t           strb,
  output logic              modeActive,
  output logic              extBlankSync
);

  localparam logic [MODE_W-1:0] MODE_ON = {MODE_W{1'b1}};

  logic hSync, fSync;
  logic hPrev, fPrev;
  logic hFall, fEdge;

  vfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSyncH (
    .clk(clk), .rstN(rstN), .d(hsyncN), .q(hSync));
  vfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uSyncF (
    .clk(clk), .rstN(rstN), .d(fieldIn), .q(fSync));
  vfd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSyncB (
    .clk(clk), .rstN(rstN), .d(extBlank), .q(extBlankSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev <= 1'b1;
      fPrev <= 1'b0;
    end else begin
      hPrev <= hSync;
      fPrev <= fSync;
    end
  end

  // lowest bit (master/slave) is forced so it cannot matter
  assign modeActive = ((modeSel | MODE_W'(1)) == MODE_ON);

  assign hFall = hPrev & ~hSync;
  assign fEdge = hSync & (fSync ^ fPrev);

  always_comb begin
    strb.lineAdv   = modeActive & hFall;
    strb.fieldLoad = modeActive & fEdge;
    strb.fieldVal  = fSync;
    strb.frameLoad = modeActive & fEdge & ~fSync;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.lineAdv && strb.fieldLoad)); // R6

endmodule

// File: rtl/vfd_datapath.sv
module vfd_datapath
  import vfd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    modeActive,
  input  logic    std625,
  input  logic    blankEn,
  input  logic    extBlankSync,
  output line_t   lineNum,
  output logic    fieldId,
  output logic    frameStart,
  output logic    blankOut
);

  line_t total;
  line_t nextLine;

  assign total    = frameLength(std625);
  assign nextLine = (lineNum >= total) ? line_t'(1) : lineNum + line_t'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineNum    <= line_t'(1);
      fieldId    <= 1'b0;
      frameStart <= 1'b0;
      blankOut   <= 1'b1;
    end else begin
      if (strb.frameLoad)    lineNum <= line_t'(1);
      else if (strb.lineAdv) lineNum <= nextLine;
      if (strb.fieldLoad)    fieldId <= strb.fieldVal;
      frameStart <= strb.frameLoad;
      if (!modeActive)   blankOut <= 1'b1;
      else if (blankEn)  blankOut <= extBlankSync;
      else               blankOut <= stdBlank(std625, lineNum);
    end
  end

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum != '0) && (lineNum <= line_t'(LINES_625))); // R3

  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lineAdv && !strb.frameLoad && lineNum == total) |=> (lineNum == line_t'(1))); // R3

  AST_FS_LINE1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineNum == line_t'(1) && !fieldId)); // R4

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> ($stable(lineNum) && $stable(fieldId) && !frameStart)); // R10

endmodule

// File: rtl/vfield_decoder.sv
module vfield_decoder
  import vfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              fieldIn,
  input  logic              extBlank,
  input  logic              blankEn,
  input  logic              std625,
  input  logic [2:0]        modeSel,
  output logic [LINE_W-1:0] lineNum,
  output logic              fieldId,
  output logic              frameStart,
  output logic              blankOut
);

  strobe_t strb;
  logic    modeActive;
  logic    extBlankSync;
  line_t   lineQ;

  vfd_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MODE_W(3)) uCtrl (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .fieldIn(fieldIn),
    .extBlank(extBlank), .modeSel(modeSel), .strb(strb),
    .modeActive(modeActive), .extBlankSync(extBlankSync));

  vfd_datapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .modeActive(modeActive),
    .std625(std625), .blankEn(blankEn), .extBlankSync(extBlankSync),
    .lineNum(lineQ), .fieldId(fieldId), .frameStart(frameStart),
    .blankOut(blankOut));

  assign lineNum = lineQ;

endmodule

// File: tb/tb_vfield_decoder.sv
module tb_vfield_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hsyncN = 1'b1;
  logic       fieldIn = 1'b0;
  logic       extBlank = 1'b1;
  logic       blankEn = 1'b0;
  logic       std625 = 1'b0;
  logic [2:0] modeSel = 3'b110;
  logic [9:0] lineNum;
  logic       fieldId, frameStart, blankOut;

  int    vectors = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R1";

  // reference state
  int mLine = 1;
  bit mField = 0, mFs = 0, mBlank = 1;
  bit hH[4], hF[4], hB[4];

  vfield_decoder dut (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .fieldIn(fieldIn),
    .extBlank(extBlank), .blankEn(blankEn), .std625(std625),
    .modeSel(modeSel), .lineNum(lineNum), .fieldId(fieldId),
    .frameStart(frameStart), .blankOut(blankOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit refBlank(bit s625, int ln);
    if (s625) return (ln <= 22) || (ln >= 311 && ln <= 335);
    return (ln <= 21) || (ln >= 263 && ln <= 283);
  endfunction

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model, evaluated a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin hH[i] = 1; hF[i] = 0; hB[i] = 1; end
      mLine = 1; mField = 0; mFs = 0; mBlank = 1;
    end else begin
      bit act;
      int tot;
      int prevLine;
      for (int i = 3; i > 0; i--) begin hH[i] = hH[i-1]; hF[i] = hF[i-1]; hB[i] = hB[i-1]; end
      hH[0] = hsyncN; hF[0] = fieldIn; hB[0] = extBlank;
      act = (modeSel[2:1] == 2'b11);
      tot = std625 ? 625 : 525;
      prevLine = mLine;
      mFs = 0;
      if (!act) mBlank = 1;
      else if (blankEn) mBlank = hB[2];
      else mBlank = refBlank(std625, prevLine);
      if (act) begin
        if (hH[3] && !hH[2]) mLine = (mLine >= tot) ? 1 : mLine + 1;
        else if (hH[2] && (hF[2] != hF[3])) begin
          mField = hF[2];
          if (!hF[2]) begin mLine = 1; mFs = 1; end
        end
      end
    end
    vectors++;
    cmp("lineNum", int'(lineNum), mLine);
    cmp("fieldId", int'(fieldId), int'(mField));
    cmp("frameStart", int'(frameStart), int'(mFs));
    cmp("blankOut", int'(blankOut), int'(mBlank));
  end

  // one line of 8 clocks; fAct: 0 none, 1 field change in sync-high part, 2 inside the sync pulse
  task automatic runLine(int fAct, bit fVal, bit extToggle);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      hsyncN = (c < 2) ? 1'b0 : 1'b1;
      if (fAct == 2 && c == 1) fieldIn = fVal;
      if (fAct == 1 && c == 4) fieldIn = fVal;
      if (extToggle && (c % 3 == 0)) extBlank = ~extBlank;
    end
  endtask

  // full frame with a second-field change and a closing frame start
  task automatic runFrame(bit s625);
    int tot = s625 ? 625 : 525;
    for (int l = 1; l <= tot; l++) begin
      if (l == (s625 ? 312 : 262)) runLine(1, 1'b1, 1'b0);
      else if (l == tot)            runLine(1, 1'b0, 1'b0);
      else                          runLine(0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    // R1: reset values, during and just after reset
    tag = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    tag = "R2";
    for (int l = 0; l < 10; l++) runLine(0, 1'b0, 1'b0);

    tag = "R4";
    runLine(1, 1'b1, 1'b0);
    runLine(1, 1'b0, 1'b0);
    runLine(0, 1'b0, 1'b0);

    tag = "R5";
    runLine(1, 1'b1, 1'b0);
    runLine(0, 1'b0, 1'b0);

    tag = "R6";
    runLine(2, 1'b0, 1'b0);
    runLine(2, 1'b1, 1'b0);
    runLine(2, 1'b0, 1'b0);
    runLine(1, 1'b0, 1'b0);

    tag = "R3";
    for (int l = 0; l < 530; l++) runLine(0, 1'b0, 1'b0);

    tag = "R7";
    runLine(1, 1'b1, 1'b0);
    runLine(1, 1'b0, 1'b0);
    runFrame(1'b0);

    tag = "R8";
    std625 = 1'b1;
    runFrame(1'b1);
    runFrame(1'b1);
    tag = "R3";
    for (int l = 0; l < 630; l++) runLine(0, 1'b0, 1'b0);

    tag = "R9";
    blankEn = 1'b1;
    for (int l = 0; l < 30; l++) runLine(0, 1'b0, 1'b1);
    blankEn = 1'b0;

    tag = "R10";
    modeSel = 3'b111;
    for (int l = 0; l < 5; l++) runLine(0, 1'b0, 1'b0);
    runLine(1, 1'b1, 1'b0);
    runLine(1, 1'b0, 1'b0);
    for (int l = 0; l < 4; l++) runLine(0, 1'b0, 1'b0);
    modeSel = 3'b010;
    for (int l = 0; l < 4; l++) runLine(0, 1'b0, 1'b0);
    runLine(1, 1'b1, 1'b0);
    runLine(1, 1'b0, 1'b0);
    modeSel = 3'b100;
    runLine(1, 1'b1, 1'b0);
    runLine(0, 1'b0, 1'b0);
    modeSel = 3'b110;
    for (int l = 0; l < 4; l++) runLine(0, 1'b0, 1'b0);
    runLine(1, 1'b0, 1'b0);
    repeat (8) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog %s: got timeout expected completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule